// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static memory. It accepts one command per clock, a read or a write, with no idle cycle needed when the direction of the data bus changes. The block registers every input on the rising clock edge. Both kinds of command place their data two enabled clocks after the command: a write takes its data from `din` at that edge, and a read presents its word on `dout` after that edge. Because the two data slots line up, a shared bus can be fully occupied by any mix of reads and writes.

A read that targets a word whose write is still in flight returns the new contents. A two-bit burst counter can generate up to four addresses from one loaded start address, in wrapping linear order or in interleaved (XOR) order. A clock-enable input freezes the whole block. Three chip selects of mixed polarity gate every loaded command.

Top module: `pipe_sram`

## Requirements
- R1: A command is taken on a rising edge only when `clk_en_n` is 0, `cs0_n` is 0, `cs1` is 1 and `cs2_n` is 0. `rw_n` = 1 selects a read and `rw_n` = 0 selects a write.
- R2: For a read taken at enabled edge k, `dout` carries the addressed word and `dout_en` is 1 after enabled edge k+2. In slots that hold no read, `dout` keeps its last value.
- R3: For a write taken at enabled edge k, the data on `din` is stored at enabled edge k+2. Lane i is bits [i*LANE_W +: LANE_W], and it is written only when `byte_we_n[i]` is 0. The byte enables are registered together with the address.
- R4: Reads and writes may alternate on consecutive enabled clocks in any order. No idle slot is needed, and every slot carries its own command's data.
- R5: A read that follows a write to the same word returns the written lanes merged with the old unwritten lanes. This holds with one command between them or none.
- R6: A loaded cycle with any chip select inactive issues no command. Its data slot has `dout_en` = 0, and the memory is unchanged.
- R7: While `clk_en_n` is 1, no state changes. `dout` and `dout_en` hold, no write happens, and no command advances.
- R8: `adv_ld` = 0 loads a new address, operation and selection. `adv_ld` = 1 issues the next burst address with the operation and selection of the last load. The address bits above bit 1 stay fixed during a burst.
- R9: On the n-th advance after a load, the low two address bits are (start + n) mod 4 when `burst_ilv` was 0 at the load, and start XOR (n mod 4) when it was 1. The sequence wraps after four addresses.
- R10: A synchronous active-high `rst` clears `dout` and `dout_en` and empties the pipeline, whatever the state of `clk_en_n`. It also leaves the burst state deselected, so an advance after reset issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| rw_n | input | 1 | 1 read, 0 write |
| addr | input | ADDR_W | Word address |
| byte_we_n | input | LANES | Per-lane write enable, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data, sampled in the write's data slot |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | High when `dout` holds a read result for this slot |

## Verification
The memory is first filled with a distinct value per address, so every read identifies the word it reached. Directed sequences then cover the following cases:
- Strict read/write alternation separates a correct data-slot alignment from an off-by-one.
- A read right after a full or partial write, and a read one slot after such a write, separates forwarding from the stale-array path and checks the lane merge.
- Deselected writes, one per chip select, and frozen clock-enable windows, placed both with reads in flight and with no reads in flight, tell real inhibition apart from a slot that merely shifted.
- Linear and interleaved bursts from several start offsets, run past four advances, separate the two orders and check the wrap.

Fixed-seed random traffic, packed densely into sixteen addresses, mixes all of these and so produces many address collisions.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    localparam int BURST_BITS = 2;

    // low address bits of a burst beat: wrapping add or XOR with the beat index
    function automatic logic [BURST_BITS-1:0] burst_lo(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input logic                  ilv
    );
        logic [BURST_BITS-1:0] r;
        if (ilv) r = start ^ beat;
        else     r = start + beat;
        return r;
    endfunction

    // all three selects asserted, each in its own polarity
    function automatic logic chip_sel(
        input logic s0_n,
        input logic s1,
        input logic s2_n
    );
        return !s0_n && s1 && !s2_n;
    endfunction

    function automatic op_e op_of(input logic rd_n_wr);
        return rd_n_wr ? OP_RD : OP_WR;
    endfunction

endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic              sel_in,
    input  logic              ilv_in,
    input  op_e               op_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cmd_vld,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    logic [HI_W-1:0]       base_hi;
    logic [BURST_BITS-1:0] base_lo;
    logic [BURST_BITS-1:0] beat_q;
    logic [BURST_BITS-1:0] beat_nx;
    logic                  ilv_q;
    logic                  sel_q;
    op_e                   op_q;

    assign beat_nx = beat_q + 1'b1;

    always_comb begin
        if (load) begin
            cmd_vld  = sel_in;
            cmd_op   = op_in;
            cmd_addr = addr_in;
        end else begin
            cmd_vld  = sel_q;
            cmd_op   = op_q;
            cmd_addr = {base_hi, burst_lo(base_lo, beat_nx, ilv_q)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            base_lo <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
            sel_q   <= 1'b0;
            op_q    <= OP_RD;
        end else if (en) begin
            if (load) begin
                base_hi <= addr_in[ADDR_W-1:BURST_BITS];
                base_lo <= addr_in[BURST_BITS-1:0];
                beat_q  <= '0;
                ilv_q   <= ilv_in;
                sel_q   <= sel_in;
                op_q    <= op_in;
            end else begin
                beat_q  <= beat_nx;
            end
        end
    end

endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_vld,
    input  op_e               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_we_n,
    output logic              s1_vld,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              s2_vld,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_we_n
);
    localparam int STAGES = 2;

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  we_n;
    } cmd_t;

    cmd_t head;
    assign head = '{vld: in_vld, op: in_op, addr: in_addr, we_n: in_we_n};

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        cmd_t nxt;
        cmd_t q;
        if (i == 0) begin : g_first
            assign nxt = head;
        end else begin : g_rest
            assign nxt = g_stg[i-1].q;
        end
        always_ff @(posedge clk) begin
            if (rst)     q <= '0;
            else if (en) q <= nxt;
        end
    end

    assign s1_vld  = g_stg[0].q.vld;
    assign s1_op   = g_stg[0].q.op;
    assign s1_addr = g_stg[0].q.addr;
    assign s2_vld  = g_stg[STAGES-1].q.vld;
    assign s2_op   = g_stg[STAGES-1].q.op;
    assign s2_addr = g_stg[STAGES-1].q.addr;
    assign s2_we_n = g_stg[STAGES-1].q.we_n;

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    en,
    input  logic                    rd_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_req,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_we_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic same_word;
    assign same_word = (wr_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        logic [LANE_W-1:0] rd_q;
        logic [LANE_W-1:0] wr_lane;
        logic              lane_wr;

        assign wr_lane = wr_data[l*LANE_W +: LANE_W];
        assign lane_wr = en && wr_req && !wr_we_n[l];

        always_ff @(posedge clk) begin
            if (lane_wr)
                arr[wr_addr] <= wr_lane;
            if (en && rd_req)
                rd_q <= (lane_wr && same_word) ? wr_lane : arr[rd_addr];
        end

        assign rd_word[l*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    adv_ld,
    input  logic                    rw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    burst_ilv,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    logic              en;
    logic              cmd_vld;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              s1_vld, s2_vld;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s2_we_n;
    logic [DATA_W-1:0] rd_word;
    logic              s1_rd, s2_rd, s2_wr;

    assign en = !clk_en_n;

    sram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load     (!adv_ld),
        .sel_in   (chip_sel(cs0_n, cs1, cs2_n)),
        .ilv_in   (burst_ilv),
        .op_in    (op_of(rw_n)),
        .addr_in  (addr),
        .cmd_vld  (cmd_vld),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr)
    );

    sram_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .in_vld  (cmd_vld),
        .in_op   (cmd_op),
        .in_addr (cmd_addr),
        .in_we_n (byte_we_n),
        .s1_vld  (s1_vld),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s2_vld  (s2_vld),
        .s2_op   (s2_op),
        .s2_addr (s2_addr),
        .s2_we_n (s2_we_n)
    );

    assign s1_rd = s1_vld && (s1_op == OP_RD);
    assign s2_rd = s2_vld && (s2_op == OP_RD);
    assign s2_wr = s2_vld && (s2_op == OP_WR);

    sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .en      (en),
        .rd_req  (s1_rd),
        .rd_addr (s1_addr),
        .wr_req  (s2_wr),
        .wr_addr (s2_addr),
        .wr_we_n (s2_we_n),
        .wr_data (din),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (en) begin
            dout_en <= s2_rd;
            if (s2_rd) dout <= rd_word;
        end
    end

    // R7
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(dout) && $stable(dout_en)));

    // R2
    rd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (en && s2_vld && s2_op == OP_RD) |=> dout_en);

    // R3
    wr_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (en && s2_vld && s2_op == OP_WR) |=> !dout_en);

    // R6
    desel_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !s2_vld) |=> !dout_en);

    // R5
    fwd_full_chk: assert property (@(posedge clk) disable iff (rst)
        (en && s1_rd && s2_wr && s1_addr == s2_addr && s2_we_n == '0)
        |=> (rd_word == $past(din)));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!dout_en && dout == '0));

endmodule

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;
    localparam int CLK_NS = 10;
    localparam int AW     = 6;
    localparam int NL     = 2;
    localparam int LW     = 9;
    localparam int DW     = NL * LW;
    localparam int DEPTH  = 1 << AW;
    localparam int LIMIT  = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b1, adv_ld = 1'b0, rw_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] byte_we_n = '1;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, burst_ilv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .adv_ld(adv_ld), .rw_n(rw_n),
        .addr(addr), .byte_we_n(byte_we_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .burst_ilv(burst_ilv), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    total = 0, bad = 0, cycles = 0;
    string tag = "R10";

    // bench model
    logic [DW-1:0] mm [DEPTH];
    logic          pv [2], pw [2];
    logic [AW-1:0] pa [2];
    logic [NL-1:0] pwe [2];
    logic [DW-1:0] pd [2];
    logic          exp_en = 1'b0;
    logic [DW-1:0] exp_dout = '0;
    logic [DW-1:0] cur_d = '0;
    logic [AW-1:0] bm_base = '0;
    logic [1:0]    bm_step = '0;
    logic          bm_ilv = 1'b0, bm_sel = 1'b0, bm_wr = 1'b0;

    function automatic logic [1:0] lo_seq(input logic [1:0] s, input logic [1:0] n, input logic ilv);
        return ilv ? (s ^ n) : (s + n);
    endfunction

    function automatic logic [DW-1:0] fill_val(input int a);
        return DW'(a * 1031 + 77);
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 2; i++) begin
            pv[i] = 1'b0; pw[i] = 1'b0; pa[i] = '0; pwe[i] = '1; pd[i] = '0;
        end
        exp_en = 1'b0; exp_dout = '0;
        bm_base = '0; bm_step = '0; bm_ilv = 1'b0; bm_sel = 1'b0; bm_wr = 1'b0;
    endtask

    task automatic model_edge();
        logic          nv, nw;
        logic [AW-1:0] na;
        if (clk_en_n) return;
        if (pv[1] && pw[1])
            for (int l = 0; l < NL; l++)
                if (!pwe[1][l]) mm[pa[1]][l*LW +: LW] = din[l*LW +: LW];
        exp_en = pv[1] && !pw[1];
        if (exp_en) exp_dout = mm[pa[1]];
        if (!adv_ld) begin
            nv = !cs0_n && cs1 && !cs2_n; nw = !rw_n; na = addr;
            bm_base = addr; bm_step = '0; bm_ilv = burst_ilv; bm_sel = nv; bm_wr = nw;
        end else begin
            bm_step = bm_step + 2'd1;
            nv = bm_sel; nw = bm_wr;
            na = {bm_base[AW-1:2], lo_seq(bm_base[1:0], bm_step, bm_ilv)};
        end
        pv[1] = pv[0]; pw[1] = pw[0]; pa[1] = pa[0]; pwe[1] = pwe[0]; pd[1] = pd[0];
        pv[0] = nv; pw[0] = nw; pa[0] = na; pwe[0] = byte_we_n; pd[0] = cur_d;
    endtask

    // ce bits: [0] cs0_n active, [1] cs1 active, [2] cs2_n active
    task automatic issue(input logic ck_n, input logic adv, input logic rd, input logic [AW-1:0] a,
                         input logic [NL-1:0] we, input logic [2:0] ce, input logic ilv,
                         input logic [DW-1:0] d);
        @(negedge clk);
        chk("dout_en", {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp_en});
        chk("dout", dout, exp_dout);
        clk_en_n = ck_n; adv_ld = adv; rw_n = rd; addr = a; byte_we_n = we;
        cs0_n = !ce[0]; cs1 = ce[1]; cs2_n = !ce[2]; burst_ilv = ilv;
        din = (pv[1] && pw[1]) ? pd[1] : DW'($urandom);
        cur_d = d;
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(1'b0, 1'b0, 1'b1, '0, '1, 3'b000, 1'b0, '0);
    endtask

    task automatic rd(input int a);
        issue(1'b0, 1'b0, 1'b1, AW'(a), '1, 3'b111, 1'b0, '0);
    endtask

    task automatic wr(input int a, input logic [NL-1:0] we, input logic [DW-1:0] d);
        issue(1'b0, 1'b0, 1'b0, AW'(a), we, 3'b111, 1'b0, d);
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) issue(1'b1, 1'b0, 1'b0, '0, '0, 3'b111, 1'b0, '1);
    endtask

    task automatic adv(input int n, input logic [DW-1:0] d);
        for (int i = 0; i < n; i++) issue(1'b0, 1'b1, 1'b1, '0, '0, 3'b111, 1'b0, d + DW'(i));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clk_en_n = 1'b1; adv_ld = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        tag = "R10";
        chk("reset dout_en", {{(DW-1){1'b0}}, dout_en}, '0);
        chk("reset dout", dout, '0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            total++; bad++;
            $display("FAIL R4 watchdog act=%0d exp<=%0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_clear();
        do_reset();

        // R1 R3: fill every word, full lane enables
        tag = "R3";
        for (int a = 0; a < DEPTH; a++) wr(a, '0, fill_val(a));
        idle(2);

        // R2: plain reads of filled words
        tag = "R2";
        rd(3); rd(17); rd(63); rd(0); idle(3);

        // R4: strict alternation, no idle slots
        tag = "R4";
        wr(10, '0, 18'h2AAAA); rd(11); wr(12, '0, 18'h15555); rd(10); rd(12); wr(11, '0, 18'h0F0F0);
        rd(11); wr(13, '0, 18'h3C3C3); rd(13); idle(3);

        // R5: read directly after write, full and partial lanes, then one slot apart
        tag = "R5";
        wr(20, '0, 18'h12345); rd(20);
        wr(21, 2'b10, 18'h3FFFF); rd(21);
        wr(22, 2'b01, 18'h3FFFF); rd(22);
        wr(23, '0, 18'h0ABCD); idle(1); rd(23);
        wr(24, 2'b10, 18'h00000); rd(0); rd(24); idle(3);

        // R6: each chip select inactive in turn, then observe memory
        tag = "R6";
        issue(1'b0, 1'b0, 1'b0, AW'(30), '0, 3'b110, 1'b0, 18'h11111);
        issue(1'b0, 1'b0, 1'b0, AW'(31), '0, 3'b101, 1'b0, 18'h22222);
        issue(1'b0, 1'b0, 1'b0, AW'(32), '0, 3'b011, 1'b0, 18'h33333);
        issue(1'b0, 1'b0, 1'b1, AW'(33), '1, 3'b110, 1'b0, '0);
        rd(30); rd(31); rd(32); idle(3);

        // R7: freeze with reads and a write in flight
        tag = "R7";
        rd(5); wr(6, '0, 18'h0DEAD); rd(7); hold(3); rd(6); hold(2); idle(3);

        // R8 R9: linear burst from offset 2, past the wrap
        tag = "R9";
        rd(6); adv(5, '0); idle(3);
        // interleaved burst from offset 1
        issue(1'b0, 1'b0, 1'b1, AW'(13), '1, 3'b111, 1'b1, '0); adv(4, '0); idle(3);
        // R8: burst write then interleaved burst read of the same page
        tag = "R8";
        issue(1'b0, 1'b0, 1'b0, AW'(42), '0, 3'b111, 1'b0, 18'h01000); adv(3, 18'h02000);
        issue(1'b0, 1'b0, 1'b1, AW'(43), '1, 3'b111, 1'b1, '0); adv(3, '0); idle(3);
        // advance after a deselected load issues nothing
        issue(1'b0, 1'b0, 1'b1, AW'(8), '1, 3'b101, 1'b0, '0); adv(4, '0); idle(3);
        // freeze in the middle of a burst
        rd(50); adv(1, '0); hold(2); adv(2, '0); idle(3);

        // R10: reset with reads pending, then advance with selects active
        tag = "R10";
        rd(1); rd(2);
        do_reset();
        adv(3, '0); idle(2);

        // R4: constrained random traffic on sixteen words
        tag = "R4";
        for (int i = 0; i < 1500; i++) begin
            logic          ck;
            logic          av;
            logic [2:0]    ce;
            ck = ($urandom % 10) == 0;
            av = ($urandom % 4) == 0;
            ce = (($urandom % 8) == 0) ? 3'($urandom % 7) : 3'b111;
            issue(ck, av, 1'($urandom), AW'(16 + $urandom % 16), NL'($urandom), ce,
                  1'($urandom), DW'($urandom));
        end
        idle(3);
        rd(16); rd(31); idle(3);

        finish_run();
    end

endmodule